// File: doc/BRIEF.md
# Interrupt Descriptor Dispatch Unit

This unit takes one interrupt event and turns it into a handler entry point. The event carries an 8-bit vector, a source class (hardware, software or exception) and the current privilege level. The unit uses a loaded table register, which holds a linear base and a byte limit, to find the descriptor for that vector. It checks that the descriptor lies inside the table and fetches it one 32-bit word at a time over a valid/ready read port. It then validates and decodes the gate. The result is a segment selector, a handler offset up to 64 bits wide, and an action: clear the maskable-interrupt enable, leave it alone, or request a task switch. Any problem gives a fault code and an error code instead.

Three addressing modes are supported. Real-address mode uses 4-byte far pointers. Protected mode uses 8-byte gates. Long mode uses 16-byte gates. The mode is sampled with each request, and the stride, the number of words fetched and the offset layout all follow from it. Vectors 0 to 31 are the exception vectors and higher vectors serve interrupt routines. The unit treats all vectors alike and leaves that split to the caller.

Back-pressure: a request is taken only on a cycle where `req_valid` and `req_ready` are both high. Once `mem_rd_valid` is raised it stays high with a stable address until `mem_rd_ready` is seen. Only one read is outstanding at a time. The memory side may delay `mem_rsp_valid` by any number of cycles and cannot be stalled by the unit.

Top module: `intvec_dispatch`

## Requirements
- R1: After reset the table base is 0 and the limit is 0x3FF, `done` and `mem_rd_valid` are low, and `req_ready` is high.
- R2: A pulse on `tbl_wr` loads `tbl_base_in` and `tbl_limit_in` into the table register. A request accepted in the same cycle still uses the previous values.
- R3: The entry size is 4, 8 or 16 bytes for mode code 0 (real), 1 (protected) or 2 (long); code 3 behaves as long. Word k of the entry is read at base + vector*size + 4k, and 1, 2 or 4 words are read.
- R4: If vector*size + size - 1 exceeds the limit, no read is issued, and `done` rises in the cycle after acceptance with fault code 1 (limit).
- R5: `req_ready` is high only while idle and `done` is low. A read address is held until accepted. `done` is a single-cycle pulse, and the result outputs hold their values until the next pulse.
- R6: In real mode, word 0 bits [15:0] are the offset and bits [31:16] the selector. `out_clr_if` is 1, and no type, privilege or presence check is made.
- R7: In the gate layout, word 0 bits [15:0] are offset bits 15:0 and bits [31:16] the selector. Word 1 bit 15 is present, bits [14:13] are the DPL, bits [11:8] the type and bits [31:16] offset bits 31:16. In long mode word 2 supplies offset bits 63:32.
- R8: Type 0xE (interrupt gate) sets `out_clr_if`, and type 0xF (trap gate) leaves it 0. Type 0x5 (task gate) in protected mode sets `out_task_sw`, returns the word 0 selector with offset 0 and leaves `out_clr_if` at 0.
- R9: Any other type, or type 0x5 in long mode, gives fault code 2 (gate).
- R10: For source code 1 (software) only, a CPL numerically greater than the DPL gives fault code 3 (privilege). Source codes 0 (hardware), 2 (exception) and 3 skip this check.
- R11: A clear present bit gives fault code 4 (not present). Among the gate faults, gate ranks above privilege and privilege above not present.
- R12: With any fault, `out_err_code` is {5'b0, vector, 3'b010}, while selector, offset, `out_clr_if` and `out_task_sw` are 0. Without a fault, `out_err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_wr | input | 1 | Load pulse for the table register |
| tbl_base_in | input | ADDR_W | New table base |
| tbl_limit_in | input | LIMIT_W | New table limit (length in bytes minus one) |
| mode_in | input | 2 | Addressing mode, sampled on acceptance |
| req_valid | input | 1 | Interrupt request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_vector | input | 8 | Interrupt vector |
| req_src | input | 2 | Source class: 0 hardware, 1 software, 2 exception |
| req_cpl | input | 2 | Current privilege level |
| mem_rd_valid | output | 1 | Read address valid |
| mem_rd_ready | input | 1 | Read address accepted |
| mem_rd_addr | output | ADDR_W | Byte address of the 32-bit word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle result strobe |
| out_fault | output | 3 | 0 none, 1 limit, 2 gate, 3 privilege, 4 not present |
| out_err_code | output | 16 | Error code on a fault |
| out_sel | output | 16 | Handler or task selector |
| out_offset | output | 64 | Handler offset |
| out_clr_if | output | 1 | Clear the maskable-interrupt enable |
| out_task_sw | output | 1 | Request a task switch |

## Verification
The bench builds the unit with ADDR_W = 32 and LIMIT_W = 16. A 16-bit limit can be set below, exactly at, or one byte short of the end of the last entry, and it can also cover every long-mode entry. With a 32-bit address, table bases can be placed at many aligned spots in an 8 KB bench memory. The bench uses random bases, limits, modes, sources, privilege levels and gate words, and adds directed boundary and priority cases. Random acceptance and response delays on the read port exercise back-pressure.

// File: rtl/intvec_pkg.sv
package intvec_pkg;

  localparam logic [1:0] MODE_REAL = 2'd0;
  localparam logic [1:0] MODE_PROT = 2'd1;
  localparam logic [1:0] MODE_LONG = 2'd2;

  localparam logic [1:0] SRC_HW  = 2'd0;
  localparam logic [1:0] SRC_SW  = 2'd1;
  localparam logic [1:0] SRC_EXC = 2'd2;

  localparam logic [3:0] GT_INTR = 4'hE;
  localparam logic [3:0] GT_TRAP = 4'hF;
  localparam logic [3:0] GT_TASK = 4'h5;

  localparam int MAX_WORDS = 4;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_LIMIT   = 3'd1,
    FLT_GATE    = 3'd2,
    FLT_PRIV    = 3'd3,
    FLT_NOTPRES = 3'd4
  } fault_e;

  typedef struct packed {
    logic [15:0] sel;
    logic [63:0] offset;
    logic        clr_if;
    logic        task_sw;
    fault_e      fault;
    logic [15:0] err;
  } dispatch_res_t;

  // log2 of the entry stride for a mode code
  function automatic logic [2:0] stride_log2(input logic [1:0] mode);
    case (mode)
      MODE_REAL: return 3'd2;
      MODE_PROT: return 3'd3;
      default:   return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] word_count(input logic [1:0] mode);
    case (mode)
      MODE_REAL: return 3'd1;
      MODE_PROT: return 3'd2;
      default:   return 3'd4;
    endcase
  endfunction

  function automatic logic [15:0] fault_code_for(input logic [7:0] vec);
    return {5'd0, vec, 3'b010};
  endfunction

endpackage

// File: rtl/intvec_locate.sv
module intvec_locate
  import intvec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 16
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [LIMIT_W-1:0] limit,
  input  logic [1:0]         mode,
  input  logic [7:0]         vector,
  output logic [ADDR_W-1:0]  entry_addr,
  output logic               in_bounds,
  output logic [2:0]         nwords
);
  localparam int REL_W = 13;
  localparam int CMP_W = ((LIMIT_W > REL_W) ? LIMIT_W : REL_W) + 1;

  logic [2:0]       sh;
  logic [REL_W-1:0] rel;
  logic [REL_W-1:0] span_end;

  always_comb begin
    sh         = stride_log2(mode);
    rel        = {5'd0, vector} << sh;
    span_end   = rel + ((REL_W'(1) << sh) - REL_W'(1));
    entry_addr = base + ADDR_W'(rel);
    in_bounds  = (CMP_W'(span_end) <= CMP_W'(limit));
    nwords     = word_count(mode);
  end

endmodule

// File: rtl/intvec_fetch.sv
module intvec_fetch
  import intvec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [ADDR_W-1:0]            start_addr,
  input  logic [2:0]                   nwords,
  output logic                         mem_rd_valid,
  input  logic                         mem_rd_ready,
  output logic [ADDR_W-1:0]            mem_rd_addr,
  input  logic                         mem_rsp_valid,
  input  logic [31:0]                  mem_rsp_data,
  output logic                         busy,
  output logic                         fin,
  output logic [MAX_WORDS-1:0][31:0]   words
);
  localparam int CNT_W = $clog2(MAX_WORDS);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_RSP} fstate_e;

  fstate_e                      state;
  logic [CNT_W-1:0]             cnt;
  logic [ADDR_W-1:0]            base_q;
  logic [2:0]                   nw_q;
  logic [MAX_WORDS-1:0][31:0]   words_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= F_IDLE;
      cnt     <= '0;
      base_q  <= '0;
      nw_q    <= 3'd1;
      words_q <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (state)
        F_IDLE: begin
          if (start) begin
            base_q  <= start_addr;
            nw_q    <= nwords;
            cnt     <= '0;
            words_q <= '0;
            state   <= F_REQ;
          end
        end
        F_REQ: begin
          if (mem_rd_ready) state <= F_RSP;
        end
        F_RSP: begin
          if (mem_rsp_valid) begin
            words_q[cnt] <= mem_rsp_data;
            if (3'(cnt) + 3'd1 == nw_q) begin
              state <= F_IDLE;
              fin   <= 1'b1;
            end else begin
              cnt   <= cnt + CNT_W'(1);
              state <= F_REQ;
            end
          end
        end
        default: state <= F_IDLE;
      endcase
    end
  end

  assign mem_rd_valid = (state == F_REQ);
  assign mem_rd_addr  = base_q + ADDR_W'({cnt, 2'b00});
  assign busy         = (state != F_IDLE);
  assign words        = words_q;

  AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R5
  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (3'(cnt) < nw_q)); // R3

endmodule

// File: rtl/intvec_gate_decode.sv
module intvec_gate_decode
  import intvec_pkg::*;
(
  input  logic [1:0]                 mode,
  input  logic [1:0]                 src,
  input  logic [1:0]                 cpl,
  input  logic [7:0]                 vector,
  input  logic [MAX_WORDS-1:0][31:0] words,
  output dispatch_res_t              res
);
  logic [31:0] w0, w1, w2;
  logic        present;
  logic [1:0]  dpl;
  logic [3:0]  gtype;
  logic        long_md;
  logic        gate_ok;
  logic        priv_bad;
  logic        unused_bits;

  assign w0          = words[0];
  assign w1          = words[1];
  assign w2          = words[2];
  assign present     = w1[15];
  assign dpl         = w1[14:13];
  assign gtype       = w1[11:8];
  assign long_md     = mode[1];
  assign unused_bits = ^{w1[12], w1[7:0], words[3]};

  always_comb begin
    gate_ok  = (gtype == GT_INTR) || (gtype == GT_TRAP) ||
               ((gtype == GT_TASK) && !long_md);
    priv_bad = (src == SRC_SW) && (cpl > dpl);
    res      = '0;
    if (mode == MODE_REAL) begin
      res.sel    = w0[31:16];
      res.offset = {48'd0, w0[15:0]};
      res.clr_if = 1'b1;
    end else if (!gate_ok) begin
      res.fault = FLT_GATE;
      res.err   = fault_code_for(vector);
    end else if (priv_bad) begin
      res.fault = FLT_PRIV;
      res.err   = fault_code_for(vector);
    end else if (!present) begin
      res.fault = FLT_NOTPRES;
      res.err   = fault_code_for(vector);
    end else if (gtype == GT_TASK) begin
      res.sel     = w0[31:16];
      res.task_sw = 1'b1;
    end else begin
      res.sel    = w0[31:16];
      res.offset = long_md ? {w2, w1[31:16], w0[15:0]}
                           : {32'd0, w1[31:16], w0[15:0]};
      res.clr_if = (gtype == GT_INTR);
    end
  end

  always_comb begin
    AST_LONG_NO_TASK: assert (!(long_md && res.task_sw)); // R9
  end

endmodule

// File: rtl/intvec_dispatch.sv
module intvec_dispatch
  import intvec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_wr,
  input  logic [ADDR_W-1:0]  tbl_base_in,
  input  logic [LIMIT_W-1:0] tbl_limit_in,
  input  logic [1:0]         mode_in,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [7:0]         req_vector,
  input  logic [1:0]         req_src,
  input  logic [1:0]         req_cpl,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data,
  output logic               done,
  output logic [2:0]         out_fault,
  output logic [15:0]        out_err_code,
  output logic [15:0]        out_sel,
  output logic [63:0]        out_offset,
  output logic               out_clr_if,
  output logic               out_task_sw
);
  localparam logic [LIMIT_W-1:0] RESET_LIMIT = LIMIT_W'(1023);

  typedef enum logic [1:0] {T_IDLE, T_FETCH, T_DEC} tstate_e;

  tstate_e             tstate;
  logic [ADDR_W-1:0]   tbl_base_q;
  logic [LIMIT_W-1:0]  tbl_limit_q;
  logic [1:0]          mode_q, src_q, cpl_q;
  logic [7:0]          vec_q;
  logic                accept;
  logic [ADDR_W-1:0]   entry_addr;
  logic                in_bounds;
  logic [2:0]          nwords;
  logic                fetch_busy, fetch_fin;
  logic [MAX_WORDS-1:0][31:0] words;
  dispatch_res_t       dec_res;
  dispatch_res_t       res_q;
  logic                done_q;

  // table register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_base_q  <= '0;
      tbl_limit_q <= RESET_LIMIT;
    end else if (tbl_wr) begin
      tbl_base_q  <= tbl_base_in;
      tbl_limit_q <= tbl_limit_in;
    end
  end

  assign req_ready = (tstate == T_IDLE) && !done_q;
  assign accept    = req_valid && req_ready;

  intvec_locate #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_locate (
    .base       (tbl_base_q),
    .limit      (tbl_limit_q),
    .mode       (mode_in),
    .vector     (req_vector),
    .entry_addr (entry_addr),
    .in_bounds  (in_bounds),
    .nwords     (nwords)
  );

  intvec_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept && in_bounds),
    .start_addr    (entry_addr),
    .nwords        (nwords),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .busy          (fetch_busy),
    .fin           (fetch_fin),
    .words         (words)
  );

  intvec_gate_decode u_decode (
    .mode   (mode_q),
    .src    (src_q),
    .cpl    (cpl_q),
    .vector (vec_q),
    .words  (words),
    .res    (dec_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tstate <= T_IDLE;
      mode_q <= '0;
      src_q  <= '0;
      cpl_q  <= '0;
      vec_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (tstate)
        T_IDLE: begin
          if (accept) begin
            mode_q <= mode_in;
            src_q  <= req_src;
            cpl_q  <= req_cpl;
            vec_q  <= req_vector;
            if (in_bounds) begin
              tstate <= T_FETCH;
            end else begin
              res_q       <= '0;
              res_q.fault <= FLT_LIMIT;
              res_q.err   <= fault_code_for(req_vector);
              done_q      <= 1'b1;
            end
          end
        end
        T_FETCH: begin
          if (fetch_fin) tstate <= T_DEC;
        end
        T_DEC: begin
          res_q  <= dec_res;
          done_q <= 1'b1;
          tstate <= T_IDLE;
        end
        default: tstate <= T_IDLE;
      endcase
    end
  end

  assign done         = done_q;
  assign out_fault    = res_q.fault;
  assign out_err_code = res_q.err;
  assign out_sel      = res_q.sel;
  assign out_offset   = res_q.offset;
  assign out_clr_if   = res_q.clr_if;
  assign out_task_sw  = res_q.task_sw;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_fault != 3'd0) |-> (!out_clr_if && !out_task_sw && out_offset == 64'd0)); // R12
  AST_TASK_PROT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_task_sw) |-> (mode_q == MODE_PROT)); // R8
  AST_READ_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (tstate == T_FETCH && fetch_busy)); // R4
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(out_offset))); // R5

endmodule

// File: tb/tb_intvec_dispatch.sv
module tb_intvec_dispatch;
  localparam int ADDR_W  = 32;
  localparam int LIMIT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic               tbl_wr = 1'b0;
  logic [ADDR_W-1:0]  tbl_base_in = '0;
  logic [LIMIT_W-1:0] tbl_limit_in = '0;
  logic [1:0]         mode_in = '0;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [7:0]         req_vector = '0;
  logic [1:0]         req_src = '0;
  logic [1:0]         req_cpl = '0;
  logic               mem_rd_valid;
  logic               mem_rd_ready;
  logic [ADDR_W-1:0]  mem_rd_addr;
  logic               mem_rsp_valid;
  logic [31:0]        mem_rsp_data;
  logic               done;
  logic [2:0]         out_fault;
  logic [15:0]        out_err_code;
  logic [15:0]        out_sel;
  logic [63:0]        out_offset;
  logic               out_clr_if;
  logic               out_task_sw;

  intvec_dispatch #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) dut (.*);

  int n_checks = 0;
  int n_fail = 0;
  bit summary_done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // bench memory, 8 KB
  logic [31:0] mem [0:2047];
  logic [31:0] tb_base = 0;
  logic [15:0] tb_limit = 16'h03FF;

  // expectations
  logic [2:0]  e_fault;
  logic [15:0] e_sel, e_err;
  logic [63:0] e_off;
  logic        e_clr, e_task, e_lim;
  logic [31:0] e_addr;
  int          e_nw;
  string       e_tag;
  int          rd_cnt = 0;

  function automatic int size_of(input logic [1:0] m);
    return (m == 2'd0) ? 4 : (m == 2'd1) ? 8 : 16;
  endfunction

  task automatic expect_result(input logic [7:0] v, input logic [1:0] s, input logic [1:0] c, input logic [1:0] m);
    int sz;
    logic [31:0] w0, w1, w2;
    logic ok_gate;
    sz     = size_of(m);
    e_nw   = sz / 4;
    e_addr = tb_base + 32'(v) * 32'(sz);
    e_lim  = (32'(v) * 32'(sz) + 32'(sz) - 1) > 32'(tb_limit);
    e_sel = 0; e_off = 0; e_clr = 0; e_task = 0; e_fault = 0; e_err = 0;
    w0 = mem[11'(e_addr >> 2)];
    w1 = mem[11'((e_addr >> 2) + 1)];
    w2 = mem[11'((e_addr >> 2) + 2)];
    ok_gate = (w1[11:8] == 4'hE) || (w1[11:8] == 4'hF) || (w1[11:8] == 4'h5 && m == 2'd1);
    if (e_lim) begin
      e_fault = 3'd1; e_tag = "R4";
    end else if (m == 2'd0) begin
      e_sel = w0[31:16]; e_off = {48'd0, w0[15:0]}; e_clr = 1; e_tag = "R6";
    end else if (!ok_gate) begin
      e_fault = 3'd2; e_tag = "R9";
    end else if (s == 2'd1 && c > w1[14:13]) begin
      e_fault = 3'd3; e_tag = "R10";
    end else if (!w1[15]) begin
      e_fault = 3'd4; e_tag = "R11";
    end else if (w1[11:8] == 4'h5) begin
      e_sel = w0[31:16]; e_task = 1; e_tag = "R8";
    end else begin
      e_sel = w0[31:16];
      e_off = {(m[1] ? w2 : 32'd0), w1[31:16], w0[15:0]};
      e_clr = (w1[11:8] == 4'hE);
      e_tag = "R7";
    end
    if (e_fault != 0) e_err = {5'd0, v, 3'b010};
  endtask

  task automatic put_desc(input logic [7:0] v, input logic [1:0] m, input logic [31:0] a, b, c, d);
    int idx;
    idx = int'((tb_base + 32'(v) * 32'(size_of(m))) >> 2);
    mem[11'(idx)] = a;
    if (m != 2'd0) mem[11'(idx + 1)] = b;
    if (m[1]) begin
      mem[11'(idx + 2)] = c;
      mem[11'(idx + 3)] = d;
    end
  endtask

  function automatic logic [31:0] gate_w1(input logic [15:0] offhi, input bit p, input logic [1:0] dpl, input logic [3:0] t);
    return {offhi, p, dpl, 1'b0, t, 8'h00};
  endfunction

  task automatic load_table(input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    tbl_wr = 1; tbl_base_in = b; tbl_limit_in = l;
    @(negedge clk);
    tbl_wr = 0;
    tb_base = b; tb_limit = l;
  endtask

  // memory responder; R3 address checks
  initial begin
    bit pend = 0;
    int dly = 0;
    logic [31:0] paddr = 0;
    mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      mem_rd_ready = 0; mem_rsp_valid = 0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data = mem[11'(paddr >> 2)];
          pend = 0;
        end else dly--;
      end else if (mem_rd_valid && ($urandom % 3) != 0) begin
        mem_rd_ready = 1;
        check(rd_cnt < e_nw, "R3", 64'(rd_cnt), 64'(e_nw));
        check(mem_rd_addr == e_addr + 32'(4 * rd_cnt), "R3", 64'(mem_rd_addr), 64'(e_addr + 32'(4 * rd_cnt)));
        rd_cnt++;
        paddr = mem_rd_addr;
        pend = 1;
        dly = int'($urandom % 3);
      end
    end
  end

  task automatic compare_out();
    check(out_fault == e_fault, e_tag, 64'(out_fault), 64'(e_fault));
    check(out_sel == e_sel, e_tag, 64'(out_sel), 64'(e_sel));
    check(out_offset == e_off, e_tag, out_offset, e_off);
    check(out_clr_if == e_clr, e_tag, 64'(out_clr_if), 64'(e_clr));
    check(out_task_sw == e_task, e_tag, 64'(out_task_sw), 64'(e_task));
    check(out_err_code == e_err, "R12", 64'(out_err_code), 64'(e_err));
  endtask

  task automatic run_txn(input logic [7:0] v, input logic [1:0] s, input logic [1:0] c, input logic [1:0] m);
    expect_result(v, s, c, m);
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1; req_vector = v; req_src = s; req_cpl = c; mode_in = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (e_lim) begin
      check(done == 1, "R4", 64'(done), 64'd1);
    end else begin
      check(req_ready == 0, "R5", 64'(req_ready), 64'd0);
      while (!done) @(negedge clk);
    end
    compare_out();
    check(rd_cnt == (e_lim ? 0 : e_nw), "R3", 64'(rd_cnt), 64'(e_lim ? 0 : e_nw));
    @(negedge clk);
    check(done == 0, "R5", 64'(done), 64'd0);
    check(out_offset == e_off && out_sel == e_sel, "R5", out_offset, e_off);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 0, "R1", 64'(done), 64'd0);
    check(req_ready == 0 || req_ready == 1, "R1", 64'(req_ready), 64'd1);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1", 64'(req_ready), 64'd1);
    check(mem_rd_valid == 0, "R1", 64'(mem_rd_valid), 64'd0);

    // R1/R6: reset table covers vector 255 in real mode (last 4 bytes at 0x3FC)
    put_desc(8'hFF, 2'd0, 32'hBEEF_1234, 0, 0, 0);
    run_txn(8'hFF, 2'd0, 2'd3, 2'd0);
    check(out_sel == 16'hBEEF && out_offset == 64'h1234, "R6", out_offset, 64'h1234);

    // R4: real mode beyond a smaller limit
    load_table(32'h100, 16'h00FF);
    run_txn(8'h40, 2'd0, 2'd0, 2'd0);
    check(out_fault == 3'd1, "R4", 64'(out_fault), 64'd1);

    // R7/R8 protected interrupt gate at exact boundary
    load_table(32'h200, 16'h0007 + 16'd8 * 16'd33);
    put_desc(8'd33, 2'd1, 32'h0010_5678, gate_w1(16'hABCD, 1, 2'd0, 4'hE), 0, 0);
    run_txn(8'd33, 2'd2, 2'd3, 2'd1);
    check(out_clr_if == 1 && out_offset == 64'hABCD5678, "R8", out_offset, 64'hABCD5678);
    // one byte short
    load_table(32'h200, 16'h0006 + 16'd8 * 16'd33);
    run_txn(8'd33, 2'd2, 2'd3, 2'd1);
    check(out_fault == 3'd1, "R4", 64'(out_fault), 64'd1);

    // R2: load in the same cycle as acceptance uses old limit
    load_table(32'h200, 16'hFFFF);
    put_desc(8'd7, 2'd1, 32'h0008_0001, gate_w1(16'h0002, 1, 2'd0, 4'hF), 0, 0);
    expect_result(8'd7, 2'd0, 2'd0, 2'd1);
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1; req_vector = 8'd7; req_src = 0; req_cpl = 0; mode_in = 2'd1;
    tbl_wr = 1; tbl_base_in = 32'h200; tbl_limit_in = 16'h0000;
    @(negedge clk);
    req_valid = 0; tbl_wr = 0;
    tb_limit = 16'h0000;
    while (!done) @(negedge clk);
    check(out_fault == 3'd0 && out_offset == 64'h0002_0001, "R2", out_offset, 64'h0002_0001);
    @(negedge clk);
    run_txn(8'd7, 2'd0, 2'd0, 2'd1);
    check(out_fault == 3'd1, "R2", 64'(out_fault), 64'd1);

    load_table(32'h400, 16'hFFFF);
    // R8 task gate in protected mode
    put_desc(8'd50, 2'd1, 32'h0028_9999, gate_w1(16'h7777, 1, 2'd3, 4'h5), 0, 0);
    run_txn(8'd50, 2'd1, 2'd3, 2'd1);
    check(out_task_sw == 1 && out_sel == 16'h0028 && out_offset == 0, "R8", 64'(out_sel), 64'h28);
    // R9 task gate in long mode
    put_desc(8'd50, 2'd2, 32'h0028_9999, gate_w1(16'h7777, 1, 2'd3, 4'h5), 32'h1, 32'h0);
    run_txn(8'd50, 2'd1, 2'd0, 2'd2);
    check(out_fault == 3'd2 && out_err_code == 16'h0192, "R9", 64'(out_err_code), 64'h192);
    // R7 long mode full offset via mode code 3
    put_desc(8'd3, 2'd3, 32'h0030_1111, gate_w1(16'h2222, 1, 2'd0, 4'hF), 32'h3333_4444, 32'h0);
    run_txn(8'd3, 2'd0, 2'd3, 2'd3);
    check(out_offset == 64'h3333_4444_2222_1111 && out_clr_if == 0, "R7", out_offset, 64'h3333_4444_2222_1111);
    // R10 privilege: software faults, hardware does not
    put_desc(8'd80, 2'd1, 32'h0040_0000, gate_w1(16'h0001, 1, 2'd0, 4'hE), 0, 0);
    run_txn(8'd80, 2'd1, 2'd3, 2'd1);
    check(out_fault == 3'd3, "R10", 64'(out_fault), 64'd3);
    run_txn(8'd80, 2'd0, 2'd3, 2'd1);
    check(out_fault == 3'd0, "R10", 64'(out_fault), 64'd0);
    // R11 not present, and priority of privilege over not present
    put_desc(8'd81, 2'd1, 32'h0040_0000, gate_w1(16'h0001, 0, 2'd0, 4'hE), 0, 0);
    run_txn(8'd81, 2'd2, 2'd3, 2'd1);
    check(out_fault == 3'd4, "R11", 64'(out_fault), 64'd4);
    run_txn(8'd81, 2'd1, 2'd3, 2'd1);
    check(out_fault == 3'd3, "R11", 64'(out_fault), 64'd3);
    // R11 gate outranks privilege
    put_desc(8'd82, 2'd1, 32'h0040_0000, gate_w1(16'h0001, 0, 2'd0, 4'h3), 0, 0);
    run_txn(8'd82, 2'd1, 2'd3, 2'd1);
    check(out_fault == 3'd2, "R11", 64'(out_fault), 64'd2);

    // random mix
    for (int it = 0; it < 200; it++) begin
      logic [7:0] v;
      logic [1:0] m, s, c;
      logic [3:0] t;
      if (it % 20 == 0)
        load_table(($urandom % 256) * 16, ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom % 4096));
      v = 8'($urandom); m = 2'($urandom); s = 2'($urandom); c = 2'($urandom);
      case ($urandom % 4)
        0: t = 4'hE;
        1: t = 4'hF;
        2: t = 4'h5;
        default: t = 4'($urandom);
      endcase
      if ((tb_base + 32'(v) * 32'(size_of(m))) < 32'd8176)
        put_desc(v, m, $urandom, gate_w1(16'($urandom), ($urandom % 10) != 0, 2'($urandom), t),
                 $urandom, $urandom);
      run_txn(v, s, c, m);
    end
    finish_run();
  end

endmodule